// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a target on an I2C bus that behaves like a small serial EEPROM. The SCL and SDA levels are sampled into the system clock domain. The block detects start and stop conditions and compares the incoming 7-bit address against its own. Its own address is a fixed 4-bit type code followed by three strap pins. When it wins the address match, it takes the first byte of a write as its internal register pointer. It stores each further byte in a small register array and advances the pointer after every byte.

After a repeated start with the read bit set, the block sends bytes from the pointer location for as long as the master acknowledges them. When the master answers a byte with NACK, the block stops sending.

A write transfer that stored at least one byte and then closes with a stop puts the block into a timed internal write cycle. During that cycle it refuses to acknowledge its own address. SDA is never driven high: the block only pulls the line low, and a pull-up on the board supplies the high level.

Top module: `seeprom_target`

## Requirements
- R1: The address byte carries the 7-bit address in bits 7..1 and the direction in bit 0 (1 = read). The address matches when bits 7..4 equal `TYPE_CODE` and bits 3..1 equal `strap`. On a match the block acknowledges by pulling SDA low through the 9th SCL pulse.
- R2: After an address that does not match, the block drives SDA at no point until the next start condition. It stores nothing in that time.
- R3: `sdaDriveLow` changes only while SCL is low. An acknowledge begins after the 8th SCL falling edge of a byte and ends at the 9th falling edge.
- R4: In a write transfer, the first byte after the address loads the register pointer from its low log2(`MEM_DEPTH`) bits. The block acknowledges this byte.
- R5: Each later byte of a write transfer is stored at the pointer and acknowledged, and then the pointer advances by one.
- R6: After a read address, the block sends the byte at the pointer, most significant bit first, and then advances the pointer. A random read (write address, pointer byte, repeated start, read address) returns the addressed register.
- R7: If the master acknowledges a read byte, the next byte follows. On a NACK the block releases SDA and stays silent until the next start.
- R8: The pointer wraps from `MEM_DEPTH`-1 to 0, for both writes and reads.
- R9: A stop that ends a transfer in which at least one byte was stored starts a busy period of `WRITE_CYCLES` system clocks. During that period the block does not acknowledge its address. After the period it acknowledges again.
- R10: After reset, SDA is released, every register holds 0 and the pointer is 0.
- R11: A stop in the middle of a byte abandons that byte. Nothing is stored and no busy period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| strap | input | 3 | Board-strapped low address bits |
| sdaDriveLow | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The hardest states to reach are those that depend on when a bus event falls against the internal write timer and the bit count. One is an address that arrives while the busy period is still running. Another is a stop placed after only half of a byte. The bench reaches the first by opening a new transfer directly after the stop that closes a write, well inside `WRITE_CYCLES`, and then repeats the same address after the timer has expired. It reaches the second with a bit-level task that stops after four data bits. A later read then confirms that the register kept its old value and that the very next address is acknowledged at once.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // capture sampled SDA into receive shifter
    logic ptrLoad;    // pointer <= received byte
    logic memWrite;   // register[pointer] <= received byte, pointer++
    logic txLoad;     // transmit shifter <= register[pointer], pointer++
    logic txShift;    // move next transmit bit to the front
    logic startBusy;  // arm the internal write-cycle timer
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } ctrlState_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_PTR,
    ROLE_DATA
  } byteRole_t;

endpackage

// File: rtl/seeprom_dpath.sv
module seeprom_dpath
  import seeprom_pkg::*;
#(
  parameter int MEM_DEPTH    = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpStrobe_t  strb,
  output logic       sclLevel,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy
);

  localparam int PTR_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam int BUSY_W  = $clog2(WRITE_CYCLES + 1);
  localparam int SYNC_N  = 2;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(MEM_DEPTH - 1);

  // ---- input synchronisers, idle-high reset ----
  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic              sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_N-1];
      sdaPrev <= sdaSync[SYNC_N-1];
    end
  end

  logic sclS, sdaS;
  assign sclS     = sclSync[SYNC_N-1];
  assign sdaS     = sdaSync[SYNC_N-1];
  assign sclLevel = sclS;
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // ---- shifters, pointer, register array ----
  logic [7:0]       rxShift, txReg;
  logic [PTR_W-1:0] ptr, ptrNext;
  logic [7:0]       mem [MEM_DEPTH];

  assign ptrNext = (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
  assign rxByte  = rxShift;
  assign txBit   = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txReg   <= '0;
      ptr     <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (strb.ptrLoad) ptr <= rxShift[PTR_W-1:0];
      if (strb.memWrite) begin
        mem[ptr] <= rxShift;
        ptr      <= ptrNext;
      end
      if (strb.txLoad) begin
        txReg <= mem[ptr];
        ptr   <= ptrNext;
      end else if (strb.txShift) begin
        txReg <= {txReg[6:0], 1'b0};
      end
    end
  end

  // ---- internal write-cycle timer ----
  logic [BUSY_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busyCnt <= '0;
    else if (strb.startBusy) busyCnt <= BUSY_W'(WRITE_CYCLES);
    else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);

  // ---- assertions ----
  p_busy_after_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.startBusy |=> busy);

  p_single_ptr_op_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrLoad, strb.memWrite, strb.txLoad}));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.memWrite || strb.txLoad) && ptr == PTR_MAX) |=> ptr == '0);

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'hA
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] strap,
  input  logic       sclLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaBit,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       busy,
  output dpStrobe_t  strb,
  output logic       sdaDriveLow
);

  ctrlState_t state;
  byteRole_t  role;
  logic [3:0] bitCnt;
  logic       rdMode, wrote, masterAck, driveLow;

  logic rxDone, addrHit, ackEnd;
  assign rxDone  = (state == ST_RX) && sclFall && (bitCnt == 4'd8);
  assign addrHit = (rxByte[7:1] == {TYPE_CODE, strap}) && !busy;
  assign ackEnd  = (state == ST_ACK) && sclFall;

  always_comb begin
    strb           = '0;
    strb.shiftIn   = (state == ST_RX) && sclRise;
    strb.ptrLoad   = rxDone && (role == ROLE_PTR);
    strb.memWrite  = rxDone && (role == ROLE_DATA);
    strb.txLoad    = (ackEnd && role == ROLE_ADDR && rdMode) ||
                     ((state == ST_TXACK) && sclFall && masterAck);
    strb.txShift   = (state == ST_TX) && sclFall && (bitCnt != 4'd8);
    strb.startBusy = stopDet && wrote;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      role      <= ROLE_ADDR;
      bitCnt    <= '0;
      rdMode    <= 1'b0;
      wrote     <= 1'b0;
      masterAck <= 1'b0;
      driveLow  <= 1'b0;
    end else if (startDet) begin
      state    <= ST_RX;
      role     <= ROLE_ADDR;
      bitCnt   <= '0;
      driveLow <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      driveLow <= 1'b0;
      wrote    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (rxDone) begin
            if (role == ROLE_ADDR && !addrHit) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_ACK;
              driveLow <= 1'b1;
              if (role == ROLE_ADDR) rdMode <= rxByte[0];
              if (role == ROLE_DATA) wrote  <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            driveLow <= 1'b0;
            bitCnt   <= '0;
            if (role == ROLE_ADDR && rdMode) begin
              state <= ST_TX;
            end else begin
              state <= ST_RX;
              role  <= (role == ROLE_ADDR) ? ROLE_PTR : ROLE_DATA;
            end
          end
        end
        ST_TX: begin
          driveLow <= ~txBit;
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            state    <= ST_TXACK;
            driveLow <= 1'b0;
          end
        end
        ST_TXACK: begin
          if (sclRise) masterAck <= ~sdaBit;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = driveLow;

  // ---- assertions ----
  p_drive_in_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> !sclLevel);

  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackEnd && !startDet && !stopDet) |=> !driveLow);

  p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && role == ROLE_ADDR && busy && !startDet && !stopDet) |=> !driveLow);

  p_nack_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_TXACK) && sclFall && !masterAck && !startDet && !stopDet)
      |=> (state == ST_IDLE && !driveLow));

endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
  import seeprom_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE    = 4'hA,
  parameter int         MEM_DEPTH    = 16,
  parameter int         WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  output logic       sdaDriveLow
);

  dpStrobe_t  strb;
  logic       sclLevel, sclRise, sclFall, startDet, stopDet, sdaBit, txBit, busy;
  logic [7:0] rxByte;

  seeprom_dpath #(
    .MEM_DEPTH   (MEM_DEPTH),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strb    (strb),
    .sclLevel(sclLevel),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet),
    .sdaBit  (sdaBit),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .busy    (busy)
  );

  seeprom_ctrl #(
    .TYPE_CODE(TYPE_CODE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strap      (strap),
    .sclLevel   (sclLevel),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .startDet   (startDet),
    .stopDet    (stopDet),
    .sdaBit     (sdaBit),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .busy       (busy),
    .strb       (strb),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/seeprom_target_tb.sv
module seeprom_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;     // system clocks per quarter bus period
  localparam int WCYC       = 400;
  localparam logic [7:0] ADDR_WR = 8'hAA;  // type A, strap 101, write
  localparam logic [7:0] ADDR_RD = 8'hAB;  // same, read
  localparam logic [7:0] ADDR_BAD = 8'hA8; // strap 100, write

  // stimulus table: {pointer, data}
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h035A, 16'h00C3, 16'h0F81,
                                         16'h0700, 16'h09FF, 16'h013C};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  wire  sdaBus = sdaM & ~sdaDriveLow;

  int total = 0;
  int bad = 0;
  int r3Viol = 0;
  logic prevDrive = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seeprom_target #(
    .TYPE_CODE   (4'hA),
    .MEM_DEPTH   (16),
    .WRITE_CYCLES(WCYC)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (scl),
    .sdaIn      (sdaBus),
    .strap      (3'b101),
    .sdaDriveLow(sdaDriveLow)
  );

  // R3 monitor: the drive must not move while the bus clock is high
  always @(negedge clk) begin
    if (rstN && scl && (sdaDriveLow !== prevDrive)) r3Viol++;
    prevDrive <= sdaDriveLow;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    waitQ();
    if (!scl) begin
      scl = 1'b1;
      waitQ();
    end
    sdaM = 1'b0;
    waitQ();
    scl = 1'b0;
    waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitQ();
    scl = 1'b1;
    waitQ();
    sdaM = 1'b1;
    waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i];
      waitQ();
      scl = 1'b1;
      waitQ(2);
      scl = 1'b0;
      waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1;
    waitQ();
    scl = 1'b1;
    waitQ();
    ack = ~sdaBus;
    waitQ();
    scl = 1'b0;
    waitQ();
  endtask

  task automatic readByte(input logic nack, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ();
      scl = 1'b1;
      waitQ();
      b = {b[6:0], sdaBus};
      waitQ();
      scl = 1'b0;
    end
    waitQ();
    sdaM = nack;
    waitQ();
    scl = 1'b1;
    waitQ(2);
    scl = 1'b0;
    waitQ();
    sdaM = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d);
    logic ack;
    busStart();
    sendByte(ADDR_WR, ack); check("R1 write address ack", ack, 1);
    sendByte(p, ack);       check("R4 pointer ack", ack, 1);
    sendByte(d, ack);       check("R5 data ack", ack, 1);
    busStop();
  endtask

  task automatic randomRead(input logic [7:0] p, output logic [7:0] d);
    logic ack;
    busStart();
    sendByte(ADDR_WR, ack);
    sendByte(p, ack);
    busStart();
    sendByte(ADDR_RD, ack); check("R6 read address ack", ack, 1);
    readByte(1'b1, d);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check("R10 drive released after reset", sdaDriveLow, 0);
    busStart();
    sendByte(ADDR_RD, ack); check("R1 read address ack", ack, 1);
    readByte(1'b1, d);      check("R10 register 0 after reset", d, 0);
    busStop();

    // table: write then random read back
    for (int v = 0; v < NVEC; v++) begin
      writeReg(VEC[v][15:8], VEC[v][7:0]);
      repeat (WCYC + 20) @(negedge clk);
      randomRead(VEC[v][15:8], d);
      check("R6 readback", d, VEC[v][7:0]);
    end

    // wrong strap: no ack, silent for the rest
    busStart();
    sendByte(ADDR_BAD, ack); check("R2 foreign address nack", ack, 0);
    sendByte(8'h00, ack);    check("R2 silent after mismatch", ack, 0);
    busStop();
    randomRead(8'h00, d);    check("R2 nothing stored", d, 8'hC3);

    // sequential write across the wrap point
    busStart();
    sendByte(ADDR_WR, ack);
    sendByte(8'h0E, ack);
    sendByte(8'h11, ack);    check("R5 seq byte 1 ack", ack, 1);
    sendByte(8'h22, ack);    check("R5 seq byte 2 ack", ack, 1);
    sendByte(8'h33, ack);    check("R8 wrapped byte ack", ack, 1);
    busStop();
    repeat (WCYC + 20) @(negedge clk);

    // sequential read across the wrap point
    busStart();
    sendByte(ADDR_WR, ack);
    sendByte(8'h0E, ack);
    busStart();
    sendByte(ADDR_RD, ack);
    readByte(1'b0, d);       check("R6 seq read 14", d, 8'h11);
    readByte(1'b0, d);       check("R7 next byte after ack", d, 8'h22);
    readByte(1'b1, d);       check("R8 wrapped read 0", d, 8'h33);
    repeat (4 * Q) @(negedge clk);
    check("R7 released after nack", sdaDriveLow, 0);
    busStop();

    // busy window after a write
    writeReg(8'h05, 8'h77);
    busStart();
    sendByte(ADDR_WR, ack);  check("R9 nack while busy", ack, 0);
    busStop();
    repeat (WCYC + 20) @(negedge clk);
    busStart();
    sendByte(ADDR_WR, ack);  check("R9 ack after busy", ack, 1);
    busStop();
    randomRead(8'h05, d);    check("R9 busy write kept", d, 8'h77);

    // stop in the middle of a data byte
    busStart();
    sendByte(ADDR_WR, ack);
    sendByte(8'h03, ack);
    sendBits(8'hEE, 4);
    busStop();
    busStart();
    sendByte(ADDR_WR, ack);  check("R11 no busy after abort", ack, 1);
    sendByte(8'h03, ack);
    busStart();
    sendByte(ADDR_RD, ack);
    readByte(1'b1, d);       check("R11 register unchanged", d, 8'h5A);
    busStop();

    check("R3 drive steady while SCL high", r3Viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule